// File: doc/BRIEF.md
# Polled Counter Bus Arbiter

This block sits on the channel side of a shared bus and decides which of `N_DEV` devices may use it next. It does so serially: every device raises its own request, and these are ORed onto one shared request line. While that line is high and the bus is free, the channel steps a device-number counter one value per clock cycle. The counter is broadcast on a narrow poll bus. Each device holds a comparator. A requesting device whose own number equals the broadcast value claims the bus by driving busy. That device keeps the bus until it pulses its done strobe.

The per-device comparators are modelled inside the block, so the arbiter works on its own. When an owner releases the bus, a mode input sets where the next poll starts. In resume mode the count carries on from the device after the last winner, which gives rotating fairness. In restart mode the count goes back to device 1, which gives fixed priority to low numbers. Data transfer on the bus is not part of this block.

Top module: `polled_bus_arbiter`

## Requirements
- R1: After reset the poll value is 1, busy is low and no grant bit is set.
- R2: The shared request output is high exactly when at least one bit of `req_i` is high.
- R3: Device k (k = 1..N_DEV) is `req_i[k-1]` and `grant_o[k-1]`. Polling is active when the request line is high and the bus is free. During polling, each cycle with no matching requester moves the poll value by one on the next edge, and it wraps from N_DEV to 1.
- R4: During polling, if the requester whose number equals the poll value exists, its grant bit and busy are high in that same cycle. The poll value does not move on that edge.
- R5: A granted device keeps its grant and busy until its own done strobe. During this time the poll value is frozen and other requests are not served.
- R6: A done strobe from a device that does not own the bus has no effect.
- R7: On the edge where the owner's done strobe is sampled, ownership ends. In resume mode (`resume_i`=1) the poll value becomes the winner's number plus one, wrapping N_DEV to 1. In restart mode (`resume_i`=0) it becomes 1.
- R8: With no request pending and no owner, the poll value holds and no grant is active.
- R9: In resume mode, a device that keeps requesting is granted within N_DEV cycles after polling starts.
- R10: At most one grant bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_DEV | Per-device request |
| done_i | input | N_DEV | Per-device end-of-access strobe |
| resume_i | input | 1 | 1: resume after last winner, 0: restart at device 1 |
| req_line_o | output | 1 | Shared request line |
| poll_o | output | ID_W | Broadcast device number |
| busy_o | output | 1 | Shared busy line |
| grant_o | output | N_DEV | Per-device ownership |

## Verification
The request line, the match, busy and grant are combinational in the cycle in which the inputs are applied. The bench drives inputs on the falling edge and reads these outputs 1 ns later. The poll counter and the owner register change on the next rising edge. For them, the bench computes the expected poll value at every intermediate cycle as (start + edges − 1) mod N_DEV + 1, and it expects a grant after exactly (k − start) mod N_DEV edges. Release effects are read in the half cycle after the edge that samples done.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;
  function automatic int unsigned wrap_next(int unsigned cur, int unsigned n);
    return (cur >= n) ? 1 : cur + 1;
  endfunction
endpackage

// File: rtl/poll_counter.sv
module poll_counter
  import poll_arb_pkg::*;
#(
  parameter int N_DEV = 8,
  parameter int ID_W  = $clog2(N_DEV + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            hit_i,
  input  logic            release_i,
  input  logic            resume_i,
  output logic [ID_W-1:0] poll_o
);
  localparam logic [ID_W-1:0] FIRST = ID_W'(1);

  logic [ID_W-1:0] poll_q, poll_nxt;

  assign poll_nxt = ID_W'(wrap_next(int'(poll_q), N_DEV));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                poll_q <= FIRST;
    else if (release_i)         poll_q <= resume_i ? poll_nxt : FIRST;
    else if (step_i && !hit_i)  poll_q <= poll_nxt;
  end

  assign poll_o = poll_q;

  a_r3_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_q >= FIRST) && (poll_q <= ID_W'(N_DEV)));

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !hit_i && !release_i) |=>
      (poll_q == (($past(poll_q) == ID_W'(N_DEV)) ? FIRST : $past(poll_q) + FIRST)));

  a_r4_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !release_i) |=> $stable(poll_q));

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && !resume_i) |=> (poll_q == FIRST));
endmodule

// File: rtl/dev_match.sv
module dev_match #(
  parameter int N_DEV = 8,
  parameter int ID_W  = $clog2(N_DEV + 1)
) (
  input  logic             en_i,
  input  logic [N_DEV-1:0] req_i,
  input  logic [ID_W-1:0]  poll_i,
  output logic [N_DEV-1:0] match_o
);
  // one comparator per device, device k carries number k+1
  for (genvar k = 0; k < N_DEV; k++) begin : g_cmp
    assign match_o[k] = en_i && req_i[k] && (poll_i == ID_W'(k + 1));
  end
endmodule

// File: rtl/owner_reg.sv
module owner_reg #(
  parameter int N_DEV = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] match_i,
  input  logic [N_DEV-1:0] done_i,
  output logic [N_DEV-1:0] owner_o,
  output logic             release_o
);
  logic [N_DEV-1:0] owner_q;

  assign release_o = |(owner_q & done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       owner_q <= '0;
    else if (release_o)                owner_q <= '0;
    else if (owner_q == '0 && |match_i) owner_q <= match_i;
  end

  assign owner_o = owner_q;

  a_r10_owner_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owner_q));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((owner_q != '0) && !release_o) |=> $stable(owner_q));

  a_r6_foreign_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((owner_q != '0) && ((done_i & owner_q) == '0)) |=> (owner_q == $past(owner_q)));
endmodule

// File: rtl/polled_bus_arbiter.sv
module polled_bus_arbiter #(
  parameter int N_DEV = 8,
  parameter int ID_W  = $clog2(N_DEV + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] req_i,
  input  logic [N_DEV-1:0] done_i,
  input  logic             resume_i,
  output logic             req_line_o,
  output logic [ID_W-1:0]  poll_o,
  output logic             busy_o,
  output logic [N_DEV-1:0] grant_o
);
  logic [N_DEV-1:0] match, owner;
  logic             owned, polling, hit, rel;

  assign req_line_o = |req_i;
  assign owned      = |owner;
  assign polling    = req_line_o && !owned;
  assign hit        = |match;

  dev_match #(.N_DEV(N_DEV), .ID_W(ID_W)) u_match (
    .en_i    (polling),
    .req_i   (req_i),
    .poll_i  (poll_o),
    .match_o (match)
  );

  poll_counter #(.N_DEV(N_DEV), .ID_W(ID_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (polling),
    .hit_i     (hit),
    .release_i (rel),
    .resume_i  (resume_i),
    .poll_o    (poll_o)
  );

  owner_reg #(.N_DEV(N_DEV)) u_own (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .match_i   (match),
    .done_i    (done_i),
    .owner_o   (owner),
    .release_o (rel)
  );

  // busy rises in the match cycle so the poll value never passes the winner
  assign busy_o  = owned || hit;
  assign grant_o = owner | match;

  a_r10_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_line_o && !busy_o) |=> $stable(poll_o));

  a_r8_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_line_o && !owned) |-> (grant_o == '0));

  a_r4_busy_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (grant_o != '0));
endmodule

// File: tb/tb_polled_bus_arbiter.sv
`timescale 1ns/1ps
module tb_polled_bus_arbiter;
  localparam int N    = 8;
  localparam int ID_W = $clog2(N + 1);

  logic clk_i = 0, rst_ni = 0, resume_i = 0;
  logic [N-1:0] req_i = '0, done_i = '0;
  logic req_line_o, busy_o;
  logic [ID_W-1:0] poll_o;
  logic [N-1:0] grant_o;

  int checks = 0, errors = 0, cur;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  polled_bus_arbiter #(.N_DEV(N)) dut (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic int pos(int s, int i);
    return ((s - 1 + i) % N) + 1;
  endfunction

  // request dev starting from poll value s, expect grant after lat edges
  task automatic await_grant(int dev, int s, int lat);
    for (int i = 0; i <= lat; i++) begin
      #1;
      chk($countones(grant_o) <= 1, "R10 grant onehot", $countones(grant_o), 1);
      if (i < lat) begin
        chk(int'(poll_o) == pos(s, i), "R3 poll step", int'(poll_o), pos(s, i));
        chk(grant_o == '0, "R3 no early grant", int'(grant_o), 0);
        tick();
      end else begin
        chk(int'(poll_o) == dev, "R4 poll at winner", int'(poll_o), dev);
        chk(grant_o == N'(1) << (dev - 1) && busy_o, "R4 grant+busy",
            int'(grant_o), 1 << (dev - 1));
        chk(lat < N, "R9 latency bound", lat + 1, N);
      end
    end
  endtask

  task automatic release_bus(int dev, bit keep, int exp_poll);
    done_i[dev-1] = 1'b1;
    if (!keep) req_i[dev-1] = 1'b0;
    tick();
    done_i = '0;
    #1;
    chk(int'(poll_o) == exp_poll, "R7 poll after release", int'(poll_o), exp_poll);
    if (req_i == '0) chk(!busy_o && grant_o == '0, "R7 bus free", int'(busy_o), 0);
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    #1;
    chk(int'(poll_o) == 1 && !busy_o && grant_o == '0, "R1 reset", int'(poll_o), 1);
    rst_ni = 1;
    repeat (3) tick();
    #1;
    chk(int'(poll_o) == 1 && grant_o == '0, "R8 idle hold", int'(poll_o), 1);
    chk(!req_line_o, "R2 line low", int'(req_line_o), 0);

    // restart mode, device 3 then foreign traffic
    @(negedge clk_i);
    req_i[2] = 1'b1;
    #1 chk(req_line_o, "R2 line high", int'(req_line_o), 1);
    await_grant(3, 1, 2);
    tick();
    req_i[0] = 1'b1;
    repeat (3) tick();
    #1;
    chk(grant_o == 8'h04 && busy_o && int'(poll_o) == 3, "R5 hold", int'(grant_o), 4);
    done_i[0] = 1'b1;
    tick();
    done_i = '0;
    #1 chk(grant_o == 8'h04 && busy_o, "R6 foreign done", int'(grant_o), 4);
    release_bus(3, 0, 1);
    chk(grant_o == 8'h01 && busy_o, "R7 restart then R4 dev1", int'(grant_o), 1);
    tick();
    release_bus(1, 0, 1);

    // restart mode sweep
    for (int k = 1; k <= N; k++) begin
      req_i[k-1] = 1'b1;
      await_grant(k, 1, k - 1);
      tick();
      release_bus(k, 0, 1);
      tick();
      #1 chk(int'(poll_o) == 1 && grant_o == '0, "R8 idle after", int'(poll_o), 1);
    end

    // resume mode sweep over start point and requester
    resume_i = 1'b1;
    cur = 1;
    for (int w = 1; w <= N; w++) begin
      for (int k = 1; k <= N; k++) begin
        req_i[w-1] = 1'b1;
        await_grant(w, cur, (w - cur + N) % N);
        tick();
        cur = w % N + 1;
        release_bus(w, 0, cur);
        req_i[k-1] = 1'b1;
        await_grant(k, cur, (k - cur + N) % N);
        tick();
        cur = k % N + 1;
        release_bus(k, 0, cur);
      end
    end

    // all requesting, resume mode rotates
    req_i = '1;
    #1 chk(grant_o == N'(1) << (cur - 1), "R9 rotate first", int'(grant_o), 1 << (cur - 1));
    for (int i = 0; i < 2 * N; i++) begin
      tick();
      release_bus(cur, 1, cur % N + 1);
      cur = cur % N + 1;
      chk(grant_o == N'(1) << (cur - 1), "R9 rotate next", int'(grant_o), 1 << (cur - 1));
    end

    // all requesting, restart mode favours device 1
    resume_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      release_bus(cur, 1, 1);
      cur = 1;
      chk(grant_o == 8'h01, "R7 priority dev1", int'(grant_o), 1);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule